// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides which group of threads uses the execution datapath of one multiprocessor in each cycle. Thread blocks are launched into a shared pool of warp slots. Each slot holds one 32-thread warp. Many warps can be resident at once, but only one of them drives the 8-lane datapath at any time. A warp instruction takes four back-to-back passes of eight threads each.

The surrounding logic tells the scheduler two things. It reports when each warp's operands are available, and it reports when a warp has run to completion. Whenever the current warp is on its last pass, or the datapath is empty, the scheduler picks the next eligible warp in round-robin order. That warp starts on the very next cycle, so changing warps costs no idle cycles.

Each issued pass carries the slot number, the pass index and a per-lane enable. The lane enable switches off the threads that a block's final, partially filled warp does not have. When every warp of a block has finished, the whole block leaves the pool at once, and its slots can be reused on the following cycle.

Top module: `warp_sched`

## Requirements
- R1: After reset, issue_valid is 0, idle is 1 and no slot is allocated. Even with every operand-ready bit at 1, nothing is issued until a block is launched. The round-robin pointer starts at the highest slot, so the first warp picked is the lowest-numbered eligible slot.
- R2: A selected warp holds the datapath for exactly four consecutive cycles. issue_slot stays the same during them and issue_pass counts 0, 1, 2, 3.
- R3: On pass p, bit i of issue_mask is 1 exactly when thread number 8*p+i is below the warp's live count. A block of T threads has ceil(T/32) warps. Every warp has 32 live threads except the block's last one, which has T-32*(ceil(T/32)-1).
- R4: If an eligible warp exists in the cycle that carries pass 3, or in any cycle with no issue, that warp's pass 0 appears on the next cycle. No idle cycle is inserted between two warps.
- R5: A warp is eligible only if three conditions hold: its slot is allocated, it has not been reported finished, and its opnd_ready bit is 1. opnd_ready is looked at only when the warp is selected.
- R6: Selection is round-robin. The search starts at the slot after the last issued slot and wraps from the highest slot to slot 0.
- R7: When no warp is eligible at a selection point, issue_valid goes to 0 and idle goes to 1, and the last warp is not repeated.
- R8: A launch of T threads, with 1 <= T <= 512, needs ceil(T/32) slots.
  - launch_ready is 1 only if that many slots are free and a block id is free.
  - The launch is accepted on a clock edge where launch_valid and launch_ready are both 1.
  - The block takes the lowest-numbered free slots in ascending order, as warps 0, 1, and so on.
  - launch_blk shows the lowest free block id, and that id is the one assigned.
- R9: A launch request with T > 512 or T = 0 sees launch_ready = 1 and launch_reject = 1. It is consumed without taking any slot or block id.
- R10: A done_valid pulse for a slot marks that warp as finished, and the warp is never selected again. The slots stay allocated until the block's last unfinished warp is reported. At that point all of the block's slots and its block id become free, and launch_ready reflects this on the next cycle.
- R11: Warps from several resident blocks share the round-robin order and are interleaved in issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_valid | input | 1 | Block launch request present |
| launch_threads | input | 11 | Thread count of the requested block |
| launch_ready | output | 1 | Request can be accepted this cycle |
| launch_reject | output | 1 | Request is out of range and is dropped |
| launch_blk | output | 3 | Block id that the request would receive |
| opnd_ready | input | 32 | Per-slot operands-available flags |
| done_valid | input | 1 | A warp has completed |
| done_slot | input | 5 | Slot of the completed warp |
| issue_valid | output | 1 | A pass is issued this cycle |
| issue_slot | output | 5 | Slot of the issuing warp |
| issue_pass | output | 2 | Pass index, 0 to 3 |
| issue_mask | output | 8 | Lane enables for this pass |
| idle | output | 1 | No pass issued this cycle |

## Verification
The assertions assume the following about the environment:
- done_slot always names an allocated warp that is not finished and is not the warp currently on the datapath.
- opnd_ready may be 1 for slots that are not allocated.
- launch_threads stays stable while launch_valid is high.

The stimulus follows these rules. It reports each warp as done only after its issue window has ended, and it never reports the same warp twice. It holds a launch request for exactly one cycle and then drops it. It deliberately leaves operand-ready bits set on finished and free slots, to show that such slots are never picked.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
    localparam int WS_SLOTS       = 32;
    localparam int WS_WARP        = 32;
    localparam int WS_LANES       = 8;
    localparam int WS_BLK_THREADS = 512;
    localparam int WS_BLOCKS      = 8;
endpackage

// File: rtl/wsc_slot_alloc.sv
// Picks the lowest free slots for a new block and counts the free pool.
module wsc_slot_alloc #(
    parameter int NS  = 32,
    parameter int WCW = 5,
    parameter int LCW = 6,
    parameter int WARP = 32,
    localparam int FCW = $clog2(NS + 1)
) (
    input  logic [NS-1:0]           free_mask,
    input  logic [WCW-1:0]          need,
    input  logic [LCW-1:0]          tail_live,
    output logic [NS-1:0]           grant_mask,
    output logic [NS-1:0][LCW-1:0]  grant_live,
    output logic [FCW-1:0]          free_cnt
);
    always_comb begin
        int k;
        int cnt;
        k = 0;
        cnt = 0;
        grant_mask = '0;
        grant_live = '0;
        for (int i = 0; i < NS; i++) begin
            if (free_mask[i]) begin
                cnt = cnt + 1;
                if (k < int'(need)) begin
                    grant_mask[i] = 1'b1;
                    grant_live[i] = (k == int'(need) - 1) ? tail_live : LCW'(WARP);
                    k = k + 1;
                end
            end
        end
        free_cnt = FCW'(cnt);
    end
endmodule

// File: rtl/wsc_first_free.sv
// Lowest-index clear bit finder.
module wsc_first_free #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wsc_rr_pick.sv
// Round-robin selector: first requester strictly after 'last', wrapping.
module wsc_rr_pick #(
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          vld,
    output logic [IW-1:0] idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int k = N; k >= 1; k--) begin
            if (req[(int'(last) + k) % N]) begin
                vld = 1'b1;
                idx = IW'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/wsc_lane_mask.sv
// Lane enables for one pass of a warp with 'live' active threads.
module wsc_lane_mask #(
    parameter int LANES = 8,
    parameter int PW    = 2,
    parameter int LCW   = 6
) (
    input  logic [LCW-1:0]   live,
    input  logic [PW-1:0]    pass,
    output logic [LANES-1:0] mask
);
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            mask[i] = (int'(pass) * LANES + i) < int'(live);
        end
    end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_SLOTS       = WS_SLOTS,
    parameter int WARP            = WS_WARP,
    parameter int LANES           = WS_LANES,
    parameter int MAX_BLK_THREADS = WS_BLK_THREADS,
    parameter int MAX_BLOCKS      = WS_BLOCKS,
    localparam int PASSES    = WARP / LANES,
    localparam int PW        = $clog2(PASSES),
    localparam int SW        = $clog2(NUM_SLOTS),
    localparam int BIW       = $clog2(MAX_BLOCKS),
    localparam int BLK_WARPS = MAX_BLK_THREADS / WARP,
    localparam int WCW       = $clog2(BLK_WARPS + 1),
    localparam int LCW       = $clog2(WARP + 1),
    localparam int LTW       = $clog2(NUM_SLOTS * WARP + 1),
    localparam int FCW       = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [LTW-1:0]       launch_threads,
    output logic                 launch_ready,
    output logic                 launch_reject,
    output logic [BIW-1:0]       launch_blk,
    input  logic [NUM_SLOTS-1:0] opnd_ready,
    input  logic                 done_valid,
    input  logic [SW-1:0]        done_slot,
    output logic                 issue_valid,
    output logic [SW-1:0]        issue_slot,
    output logic [PW-1:0]        issue_pass,
    output logic [LANES-1:0]     issue_mask,
    output logic                 idle
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0]           slot_used;
        logic [NUM_SLOTS-1:0]           slot_fin;
        logic [NUM_SLOTS-1:0][BIW-1:0]  slot_blk;
        logic [NUM_SLOTS-1:0][LCW-1:0]  slot_live;
        logic [MAX_BLOCKS-1:0]          blk_used;
        logic [MAX_BLOCKS-1:0][WCW-1:0] blk_left;
        logic                           iss_vld;
        logic [SW-1:0]                  iss_slot;
        logic [PW-1:0]                  iss_pass;
        logic [LANES-1:0]               iss_mask;
        logic [SW-1:0]                  last_slot;
    } state_t;

    state_t st_q, st_d;

    // ---------------- launch decode ----------------
    int             need_i;
    int             tail_i;
    logic           oversize;
    logic [WCW-1:0] need;
    logic [LCW-1:0] tail_live;

    always_comb begin
        need_i    = (int'(launch_threads) + WARP - 1) / WARP;
        tail_i    = int'(launch_threads) - WARP * (need_i - 1);
        oversize  = (int'(launch_threads) > MAX_BLK_THREADS) || (launch_threads == '0);
        need      = oversize ? '0 : WCW'(need_i);
        tail_live = oversize ? '0 : LCW'(tail_i);
    end

    logic [NUM_SLOTS-1:0]          grant_mask;
    logic [NUM_SLOTS-1:0][LCW-1:0] grant_live;
    logic [FCW-1:0]                free_cnt;

    wsc_slot_alloc #(
        .NS   (NUM_SLOTS),
        .WCW  (WCW),
        .LCW  (LCW),
        .WARP (WARP)
    ) i_alloc (
        .free_mask  (~st_q.slot_used),
        .need       (need),
        .tail_live  (tail_live),
        .grant_mask (grant_mask),
        .grant_live (grant_live),
        .free_cnt   (free_cnt)
    );

    logic           blk_found;
    logic [BIW-1:0] blk_pick;

    wsc_first_free #(.N(MAX_BLOCKS)) i_blkid (
        .busy  (st_q.blk_used),
        .found (blk_found),
        .idx   (blk_pick)
    );

    logic launch_fire;

    always_comb begin
        launch_reject = launch_valid && oversize;
        launch_ready  = oversize || (blk_found && (int'(need) <= int'(free_cnt)));
        launch_blk    = blk_pick;
        launch_fire   = launch_valid && launch_ready && !oversize;
    end

    // ---------------- warp selection ----------------
    logic [NUM_SLOTS-1:0] done_hot;
    logic [NUM_SLOTS-1:0] cand;
    logic                 pick_vld;
    logic [SW-1:0]        pick_slot;

    always_comb begin
        done_hot = done_valid ? (NUM_SLOTS'(1) << done_slot) : '0;
        cand     = st_q.slot_used & ~st_q.slot_fin & opnd_ready & ~done_hot;
    end

    wsc_rr_pick #(.N(NUM_SLOTS)) i_pick (
        .req  (cand),
        .last (st_q.last_slot),
        .vld  (pick_vld),
        .idx  (pick_slot)
    );

    logic          boundary;
    logic          nx_vld;
    logic [SW-1:0] nx_slot;
    logic [PW-1:0] nx_pass;

    always_comb begin
        boundary = !st_q.iss_vld || (st_q.iss_pass == PW'(PASSES - 1));
        nx_vld   = st_q.iss_vld;
        nx_slot  = st_q.iss_slot;
        nx_pass  = st_q.iss_pass + 1'b1;
        if (boundary) begin
            nx_vld  = pick_vld;
            nx_slot = pick_vld ? pick_slot : st_q.iss_slot;
            nx_pass = '0;
        end
    end

    logic [LANES-1:0] nx_mask;

    wsc_lane_mask #(
        .LANES (LANES),
        .PW    (PW),
        .LCW   (LCW)
    ) i_mask (
        .live (st_q.slot_live[nx_slot]),
        .pass (nx_pass),
        .mask (nx_mask)
    );

    // ---------------- next state ----------------
    logic [BIW-1:0] dblk;

    always_comb begin
        st_d = st_q;
        dblk = st_q.slot_blk[done_slot];

        // retirement; a block leaves the pool when its final warp reports
        if (done_valid) begin
            if (st_q.blk_left[dblk] == WCW'(1)) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (st_q.slot_used[i] && (st_q.slot_blk[i] == dblk)) begin
                        st_d.slot_used[i] = 1'b0;
                        st_d.slot_fin[i]  = 1'b0;
                    end
                end
                st_d.blk_used[dblk] = 1'b0;
                st_d.blk_left[dblk] = '0;
            end else begin
                st_d.slot_fin[done_slot] = 1'b1;
                st_d.blk_left[dblk]      = st_q.blk_left[dblk] - 1'b1;
            end
        end

        // launch into free slots (disjoint from anything retired above)
        if (launch_fire) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (grant_mask[i]) begin
                    st_d.slot_used[i] = 1'b1;
                    st_d.slot_fin[i]  = 1'b0;
                    st_d.slot_blk[i]  = blk_pick;
                    st_d.slot_live[i] = grant_live[i];
                end
            end
            st_d.blk_used[blk_pick] = 1'b1;
            st_d.blk_left[blk_pick] = need;
        end

        // issue pipeline
        st_d.iss_vld  = nx_vld;
        st_d.iss_slot = nx_slot;
        st_d.iss_pass = nx_pass;
        st_d.iss_mask = nx_vld ? nx_mask : '0;
        if (boundary && pick_vld) begin
            st_d.last_slot = pick_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.last_slot <= SW'(NUM_SLOTS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid = st_q.iss_vld;
    assign issue_slot  = st_q.iss_slot;
    assign issue_pass  = st_q.iss_pass;
    assign issue_mask  = st_q.iss_mask;
    assign idle        = !st_q.iss_vld;

endmodule

// File: rtl/wsc_chk.sv
module wsc_chk #(
    parameter int NS     = 32,
    parameter int SW     = 5,
    parameter int PW     = 2,
    parameter int LANES  = 8,
    parameter int LTW    = 11,
    parameter int PASSES = 4,
    parameter int MAXT   = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             launch_valid,
    input logic [LTW-1:0]   launch_threads,
    input logic             launch_ready,
    input logic             launch_reject,
    input logic [NS-1:0]    opnd_ready,
    input logic             issue_valid,
    input logic [SW-1:0]    issue_slot,
    input logic [PW-1:0]    issue_pass,
    input logic [LANES-1:0] issue_mask
);
    logic [NS-1:0] opnd_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) opnd_prev <= '0;
        else        opnd_prev <= opnd_ready;
    end

    // R2
    pass_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_pass != PW'(PASSES - 1)) |=>
        (issue_valid && issue_pass == $past(issue_pass) + 1'b1 && $stable(issue_slot)));

    // R5
    start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_pass == '0) |-> opnd_prev[issue_slot]);

    // R9
    reject_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && int'(launch_threads) > MAXT) |-> (launch_ready && launch_reject));

    // R3
    first_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_pass == '0) |-> issue_mask[0]);

    // R8
    stall_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && !launch_ready) |-> !launch_reject);
endmodule

bind warp_sched wsc_chk #(
    .NS     (NUM_SLOTS),
    .SW     (SW),
    .PW     (PW),
    .LANES  (LANES),
    .LTW    (LTW),
    .PASSES (PASSES),
    .MAXT   (MAX_BLK_THREADS)
) i_wsc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch_valid   (launch_valid),
    .launch_threads (launch_threads),
    .launch_ready   (launch_ready),
    .launch_reject  (launch_reject),
    .opnd_ready     (opnd_ready),
    .issue_valid    (issue_valid),
    .issue_slot     (issue_slot),
    .issue_pass     (issue_pass),
    .issue_mask     (issue_mask)
);

// File: tb/test_warp_sched.sv
`timescale 1ns/1ps
module test_warp_sched;
    localparam int NS  = 32;
    localparam int LTW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          launch_valid = 1'b0;
    logic [LTW-1:0] launch_threads = '0;
    logic          launch_ready;
    logic          launch_reject;
    logic [2:0]    launch_blk;
    logic [NS-1:0] opnd_ready = '0;
    logic          done_valid = 1'b0;
    logic [4:0]    done_slot = '0;
    logic          issue_valid;
    logic [4:0]    issue_slot;
    logic [1:0]    issue_pass;
    logic [7:0]    issue_mask;
    logic          idle;

    always #4 clk = ~clk;

    warp_sched i_warp_sched (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch_valid   (launch_valid),
        .launch_threads (launch_threads),
        .launch_ready   (launch_ready),
        .launch_reject  (launch_reject),
        .launch_blk     (launch_blk),
        .opnd_ready     (opnd_ready),
        .done_valid     (done_valid),
        .done_slot      (done_slot),
        .issue_valid    (issue_valid),
        .issue_slot     (issue_slot),
        .issue_pass     (issue_pass),
        .issue_mask     (issue_mask),
        .idle           (idle)
    );

    typedef struct {
        int    slot;
        int    pass;
        int    mask;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t item;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   started = 0;
    bit   reported = 0;
    int   cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    // expected passes of one warp, mask from its live count
    task automatic push_warp(input int slot, input int live, input string tag);
        for (int p = 0; p < 4; p++) begin
            exp_t e;
            e.slot = slot;
            e.pass = p;
            e.mask = 0;
            for (int i = 0; i < 8; i++)
                if (p * 8 + i < live) e.mask = e.mask | (1 << i);
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic launch(input int thr, input bit er, input bit ej,
                          input int eb, input string req);
        @(negedge clk);
        launch_valid   = 1'b1;
        launch_threads = LTW'(thr);
        #1;
        chk(launch_ready == er, req, "launch_ready", int'(launch_ready), int'(er));
        chk(launch_reject == ej, req, "launch_reject", int'(launch_reject), int'(ej));
        if (eb >= 0 && er)
            chk(int'(launch_blk) == eb, req, "launch_blk", int'(launch_blk), eb);
        @(negedge clk);
        launch_valid = 1'b0;
    endtask

    task automatic retire(input int slot);
        @(negedge clk);
        done_valid = 1'b1;
        done_slot  = 5'(slot);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic run_ready(input logic [NS-1:0] rdy);
        @(negedge clk);
        opnd_ready = rdy;
        wait (exp_q.size() == 0);
        @(negedge clk);
        opnd_ready = '0;
        repeat (6) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (rst_n && exp_q.size() > 0) begin
            if (issue_valid) begin
                item = exp_q.pop_front();
                started = 1;
                chk(int'(issue_slot) == item.slot, item.tag, "issue_slot", int'(issue_slot), item.slot);
                chk(int'(issue_pass) == item.pass, item.tag, "issue_pass", int'(issue_pass), item.pass);
                chk(int'(issue_mask) == item.mask, item.tag, "issue_mask", int'(issue_mask), item.mask);
                if (exp_q.size() == 0) started = 0;
            end else if (started) begin
                chk(1'b0, "R4", "bubble issue_valid", 0, 1);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R7: empty pool, all operand bits set
        @(negedge clk);
        opnd_ready = '1;
        repeat (3) @(negedge clk);
        #1;
        chk(issue_valid == 1'b0, "R1", "issue_valid empty", int'(issue_valid), 0);
        chk(idle == 1'b1, "R1", "idle empty", int'(idle), 1);
        opnd_ready = '0;

        // R8: block A, 64 threads -> slots 0,1, id 0
        launch(64, 1, 0, 0, "R8");
        // R2 R4 R6: alternate two ready warps with no gap
        push_warp(0, 32, "R2");
        push_warp(1, 32, "R4");
        push_warp(0, 32, "R6");
        push_warp(1, 32, "R4");
        run_ready(32'h3);
        #1;
        chk(idle == 1'b1, "R7", "idle after drain", int'(idle), 1);
        chk(issue_valid == 1'b0, "R7", "no repeat", int'(issue_valid), 0);

        // R3 R5: block B, 44 threads -> slots 2,3, id 1; only slot 3 ready
        launch(44, 1, 0, 1, "R8");
        push_warp(3, 12, "R3");
        run_ready(32'h8);

        // R6 R11: slots 0,2,3 ready from two blocks, last issued = 3
        push_warp(0, 32, "R11");
        push_warp(2, 32, "R6");
        push_warp(3, 12, "R11");
        push_warp(0, 32, "R6");
        run_ready(32'hD);

        // R9: out-of-range requests are consumed without allocation
        launch(600, 1, 1, -1, "R9");
        launch(0, 1, 1, -1, "R9");
        // block C, 32 threads -> slot 4, id 2
        launch(32, 1, 0, 2, "R9");
        push_warp(4, 32, "R9");
        run_ready(32'h10);

        // R8: capacity limits
        launch(512, 1, 0, 3, "R8");   // D: slots 5..20
        launch(512, 0, 0, -1, "R8");  // 11 free, 16 needed
        launch(352, 1, 0, 4, "R8");   // E: slots 21..31
        launch(32, 0, 0, -1, "R8");   // pool full
        push_warp(31, 32, "R8");
        run_ready(32'h8000_0000);

        // R10: retire single-warp block C, reuse on the next cycle
        @(negedge clk);
        done_valid     = 1'b1;
        done_slot      = 5'd4;
        launch_valid   = 1'b1;
        launch_threads = LTW'(32);
        #1;
        chk(launch_ready == 1'b0, "R10", "ready while retiring", int'(launch_ready), 0);
        @(negedge clk);
        done_valid = 1'b0;
        #1;
        chk(launch_ready == 1'b1, "R10", "ready next cycle", int'(launch_ready), 1);
        chk(int'(launch_blk) == 2, "R10", "reused block id", int'(launch_blk), 2);
        @(negedge clk);
        launch_valid = 1'b0;

        // R10: first warp of A done, block still resident
        retire(0);
        launch(32, 0, 0, -1, "R10");
        @(negedge clk);
        opnd_ready = 32'h1;
        repeat (6) @(negedge clk);
        #1;
        chk(idle == 1'b1, "R10", "finished warp not issued", int'(idle), 1);
        opnd_ready = '0;
        retire(1);
        launch(64, 1, 0, 0, "R10");
        push_warp(0, 32, "R10");
        run_ready(32'h1);

        summary();
        $finish;
    end
endmodule